// File: doc/BRIEF.md
# Chip-Select Base Allocator Sequencer

This block places the memory chip-select banks of one or more nodes into a single physical address map. A start pulse captures the size of every bank and the lowest address of the I/O window that sits just below 4 GB. The engine then works through the nodes one at a time. Within each node it places the banks from largest to smallest, packing them upward from the running top of memory. All addresses and sizes are counted in 16 MB units, and every bank size is a power of two, with zero meaning an empty bank.

When placing the next bank would push the running top past the start of the I/O window, the engine moves the rest of memory to begin at 4 GB. There are two ways to do this. If the node has placed nothing yet, the whole node moves up. Otherwise the bank alone is given a node-local offset, so that it lands at 4 GB. Either way, the top of memory below the window is recorded, and the final top above 4 GB is reported as a second value.

The results are per-bank base, mask and enable, a base for each node, and the two top-of-memory values. They stay stable after the single-cycle done pulse and remain so until the next run.

Top module: `csa_alloc_seq`

## Requirements
- R1: After reset, busy, done, every bank enable, every base, every mask and both top-of-memory outputs are 0. A start pulse while busy is 1 is ignored: the run in progress finishes with the results of the sizes captured at its own start, and no second done follows.
- R2: Within a node, banks are placed in descending size order. Of equal sizes, the lower bank index goes first. Zero-size banks stay disabled with base 0 and mask 0.
- R3: Each placed bank gets mask = size − 1 and its enable bit set. Its base is the node-local next base, which is 0 for the first bank of a node. The running top and the node-local next base then both grow by the bank size.
- R4: When a node begins, its node base is set to the running top and its local next base restarts at 0. A node with no banks keeps that base.
- R5: A hole check fires only when all three of these hold: the running top is nonzero, the running top is below 4 GB (256 units), and top + size is strictly greater than the captured I/O window start. When it fires, the low top-of-memory takes the current top and the running top jumps to 4 GB.
- R6: On a hole, if the node base equals the latched low top, the node base becomes 4 GB and the bank's local base is 0 (whole-node move).
- R7: On a hole in any other case, the bank base and the next local base become 4 GB minus the node base. This per-bank move is never applied to a 4 GB bank.
- R8: At the end of the run, one of two outcomes applies. If a hole fired, tom_high is the final running top and tom_low holds the latched value. Otherwise tom_low is the final running top and tom_high is 0.
- R9: Bank enables, bases and masks are indexed flat as node × 8 + bank. Bank b of node n uses bits [(n·8+b)·14 +: 14] of the base and mask buses and bit n·8+b of the enable bus.
- R10: busy is 1 from the cycle after an accepted start until the cycle done is 1. done is 1 for exactly one cycle per accepted start.
- R11: Each new run clears every result of the previous run before placing banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; captures bank_size and io_low |
| bank_size | input | NODES·8·14 | Bank sizes in 16 MB units, flat by node·8+bank |
| io_low | input | 14 | Start of the I/O window in 16 MB units |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cs_base | output | NODES·8·14 | Node-local base per bank |
| cs_mask | output | NODES·8·14 | Size minus one per bank |
| cs_en | output | NODES·8 | Bank placed |
| node_base | output | NODES·14 | Base address per node |
| tom_low | output | 14 | Top of memory below 4 GB |
| tom_high | output | 14 | Top of memory above 4 GB, 0 if none |

## Verification
The assertions check several rules on every cycle:
- the chosen bank is nonzero and not yet placed;
- each placement enables exactly one more bank and raises the running top;
- the hole fires at most once per run;
- the per-bank move never sees a 4 GB bank;
- done is a lone pulse, and tom_high is 0 at done when no hole occurred;
- a start while busy leaves the captured sizes untouched.

The exact address map can only be shown by the bench's scenarios, which compare every base, mask, enable, node base and top-of-memory value with an independent model. These scenarios cover tie ordering, an exact fit against the window, a hole at a zero top, the whole-node move, the per-bank move, an empty node and a rerun.

// File: rtl/csa_pkg.sv
package csa_pkg;
  parameter int ADDR_W    = 14;  // addresses counted in allocation units
  parameter int UNIT_LOG2 = 24;  // one unit is 16 MB

  typedef logic [ADDR_W-1:0] unit_t;

  localparam unit_t FOUR_G = unit_t'(64'd1 << (32 - UNIT_LOG2));

  typedef enum logic [2:0] {
    ST_IDLE, ST_NODE, ST_SCAN, ST_PLACE, ST_FIN
  } seq_state_t;

  // Would this bank run into the I/O window below 4 GB?
  function automatic logic crosses_window(unit_t top, unit_t sz, unit_t io_start);
    logic [ADDR_W:0] reach;
    reach = {1'b0, top} + {1'b0, sz};
    return (top != '0) && (top < FOUR_G) && (reach > {1'b0, io_start});
  endfunction

  function automatic unit_t size_mask(unit_t sz);
    return sz - unit_t'(1);
  endfunction

  // Local offset that lands a bank of this node at 4 GB.
  function automatic unit_t cs_offset(unit_t nbase);
    return FOUR_G - nbase;
  endfunction
endpackage

// File: rtl/csa_pick.sv
module csa_pick
  import csa_pkg::*;
#(
  parameter int BANKS = 8,
  localparam int IW = $clog2(BANKS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [BANKS*ADDR_W-1:0] sizes,
  input  logic [BANKS-1:0]        used,
  output logic                    scan_done,
  output logic                    found,
  output logic [IW-1:0]           pick_idx,
  output unit_t                   pick_size
);
  logic          active;
  logic [IW-1:0] cnt;
  unit_t         cur;
  logic          better;

  always_comb begin
    cur    = sizes[cnt*ADDR_W +: ADDR_W];
    // strict compare keeps the lowest index among equal sizes
    better = (cur != '0) && !used[cnt] && (!found || (cur > pick_size));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cnt       <= '0;
      scan_done <= 1'b0;
      found     <= 1'b0;
      pick_idx  <= '0;
      pick_size <= '0;
    end else begin
      scan_done <= 1'b0;
      if (go) begin
        active    <= 1'b1;
        cnt       <= '0;
        found     <= 1'b0;
        pick_idx  <= '0;
        pick_size <= '0;
      end else if (active) begin
        if (better) begin
          found     <= 1'b1;
          pick_size <= cur;
          pick_idx  <= cnt;
        end
        if (cnt == IW'(BANKS - 1)) begin
          active    <= 1'b0;
          scan_done <= 1'b1;
        end
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_PICK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_done && found) |-> ((pick_size != '0) && !used[pick_idx])); // R2
  AST_SCAN_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (active && !scan_done)); // R2
endmodule

// File: rtl/csa_place.sv
module csa_place
  import csa_pkg::*;
(
  input  unit_t top,
  input  unit_t sz,
  input  unit_t io_start,
  input  unit_t node_base,
  input  unit_t next_base,
  output logic  hole,
  output logic  node_hoist,
  output logic  cs_hoist,
  output unit_t new_top,
  output unit_t new_node_base,
  output unit_t bank_base,
  output unit_t new_next,
  output unit_t mask
);
  always_comb begin
    hole          = crosses_window(top, sz, io_start);
    node_hoist    = hole && (node_base == top);
    cs_hoist      = hole && !node_hoist;
    new_node_base = node_hoist ? FOUR_G : node_base;
    if (cs_hoist)        bank_base = cs_offset(node_base);
    else if (node_hoist) bank_base = '0;
    else                 bank_base = next_base;
    new_next      = bank_base + sz;
    new_top       = (hole ? FOUR_G : top) + sz;
    mask          = size_mask(sz);
  end
endmodule

// File: rtl/csa_alloc_seq.sv
module csa_alloc_seq
  import csa_pkg::*;
#(
  parameter int NODES = 2,
  parameter int BANKS = 8,
  localparam int NW = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int IW = $clog2(BANKS),
  localparam int CS = NODES * BANKS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [CS*ADDR_W-1:0]    bank_size,
  input  logic [ADDR_W-1:0]       io_low,
  output logic                    busy,
  output logic                    done,
  output logic [CS*ADDR_W-1:0]    cs_base,
  output logic [CS*ADDR_W-1:0]    cs_mask,
  output logic [CS-1:0]           cs_en,
  output logic [NODES*ADDR_W-1:0] node_base,
  output logic [ADDR_W-1:0]       tom_low,
  output logic [ADDR_W-1:0]       tom_high
);
  seq_state_t          state;
  logic [CS*ADDR_W-1:0] sizes_q;
  unit_t               io_q, top_q, next_q;
  logic [NW-1:0]       node_q;
  logic                low_seen;

  // named internal events
  logic                    go, place_fire, last_node;
  logic [BANKS*ADDR_W-1:0] node_sizes;
  logic [BANKS-1:0]        node_used;
  unit_t                   cur_nbase;
  logic                    scan_done, found;
  logic [IW-1:0]           pick_idx;
  unit_t                   pick_size;
  logic                    hole, node_hoist, cs_hoist;
  unit_t                   new_top, new_nbase, bank_base, new_next, mask;

  always_comb begin
    go         = (state == ST_NODE) || (state == ST_PLACE);
    place_fire = (state == ST_PLACE);
    last_node  = (node_q == NW'(NODES - 1));
    node_sizes = sizes_q[node_q*BANKS*ADDR_W +: BANKS*ADDR_W];
    node_used  = cs_en[node_q*BANKS +: BANKS];
    cur_nbase  = node_base[node_q*ADDR_W +: ADDR_W];
  end

  csa_pick #(.BANKS(BANKS)) u_pick (
    .clk(clk), .rst_n(rst_n), .go(go), .sizes(node_sizes), .used(node_used),
    .scan_done(scan_done), .found(found), .pick_idx(pick_idx), .pick_size(pick_size)
  );

  csa_place u_place (
    .top(top_q), .sz(pick_size), .io_start(io_q), .node_base(cur_nbase),
    .next_base(next_q), .hole(hole), .node_hoist(node_hoist), .cs_hoist(cs_hoist),
    .new_top(new_top), .new_node_base(new_nbase), .bank_base(bank_base),
    .new_next(new_next), .mask(mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      sizes_q   <= '0;
      io_q      <= '0;
      top_q     <= '0;
      next_q    <= '0;
      node_q    <= '0;
      low_seen  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cs_base   <= '0;
      cs_mask   <= '0;
      cs_en     <= '0;
      node_base <= '0;
      tom_low   <= '0;
      tom_high  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sizes_q   <= bank_size;
          io_q      <= io_low;
          top_q     <= '0;
          node_q    <= '0;
          low_seen  <= 1'b0;
          cs_base   <= '0;
          cs_mask   <= '0;
          cs_en     <= '0;
          node_base <= '0;
          tom_low   <= '0;
          tom_high  <= '0;
          busy      <= 1'b1;
          state     <= ST_NODE;
        end
        ST_NODE: begin
          node_base[node_q*ADDR_W +: ADDR_W] <= top_q;
          next_q <= '0;
          state  <= ST_SCAN;
        end
        ST_SCAN: if (scan_done) begin
          if (found)          state <= ST_PLACE;
          else if (last_node) state <= ST_FIN;
          else begin
            node_q <= node_q + 1'b1;
            state  <= ST_NODE;
          end
        end
        ST_PLACE: begin
          cs_base[(node_q*BANKS + pick_idx)*ADDR_W +: ADDR_W] <= bank_base;
          cs_mask[(node_q*BANKS + pick_idx)*ADDR_W +: ADDR_W] <= mask;
          cs_en[node_q*BANKS + pick_idx]                      <= 1'b1;
          node_base[node_q*ADDR_W +: ADDR_W]                  <= new_nbase;
          next_q <= new_next;
          top_q  <= new_top;
          if (hole) begin
            low_seen <= 1'b1;
            tom_low  <= top_q;
          end
          state <= ST_SCAN;
        end
        ST_FIN: begin
          if (low_seen) tom_high <= top_q;
          else          tom_low  <= top_q;
          done  <= 1'b1;
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_TOP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    place_fire |=> (top_q > $past(top_q))); // R3
  AST_ONE_MORE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    place_fire |=> ($countones(cs_en) == $countones($past(cs_en)) + 1)); // R3
  AST_HOLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (place_fire && hole) |-> !low_seen); // R5
  AST_CS_NOT_4G: assert property (@(posedge clk) disable iff (!rst_n)
    (place_fire && cs_hoist) |-> (pick_size != FOUR_G)); // R7
  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !low_seen) |-> (tom_high == '0)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(sizes_q)); // R1
endmodule

// File: tb/tb_csa_alloc_seq.sv
`timescale 1ns/1ps
module tb_csa_alloc_seq;
  localparam int NODES = 2;
  localparam int BANKS = 8;
  localparam int AW    = csa_pkg::ADDR_W;
  localparam int CS    = NODES * BANKS;
  localparam int FOUR  = 256;

  typedef struct packed {
    logic [CS*AW-1:0]    base;
    logic [CS*AW-1:0]    mask;
    logic [CS-1:0]       en;
    logic [NODES*AW-1:0] nb;
    logic [AW-1:0]       tl;
    logic [AW-1:0]       th;
  } exp_t;

  logic clk = 0, rst_n = 0, start = 0;
  logic [CS*AW-1:0]    bank_size = '0;
  logic [AW-1:0]       io_low = '0;
  logic                busy, done;
  logic [CS*AW-1:0]    cs_base, cs_mask;
  logic [CS-1:0]       cs_en;
  logic [NODES*AW-1:0] node_base;
  logic [AW-1:0]       tom_low, tom_high;

  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;
  exp_t exp_q[$];
  string cur_tag = "";

  always #2.5 clk = ~clk;

  csa_alloc_seq #(.NODES(NODES), .BANKS(BANKS)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_size(bank_size), .io_low(io_low),
    .busy(busy), .done(done), .cs_base(cs_base), .cs_mask(cs_mask), .cs_en(cs_en),
    .node_base(node_base), .tom_low(tom_low), .tom_high(tom_high)
  );

  task automatic chk(input bit ok, input string what, input logic [255:0] act, input logic [255:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, expv);
    end
  endtask

  function automatic logic [CS*AW-1:0] put(input logic [CS*AW-1:0] v, input int n, input int b, input int s);
    logic [CS*AW-1:0] r;
    r = v;
    r[(n*BANKS+b)*AW +: AW] = AW'(s);
    return r;
  endfunction

  // Reference: rank-based ordering, then sequential placement.
  function automatic exp_t model(input logic [CS*AW-1:0] sz, input int iol);
    exp_t e;
    int top, lowtop, nxt, nb, s, t, rk;
    bit seen;
    e = '0; top = 0; lowtop = 0; seen = 0;
    for (int n = 0; n < NODES; n++) begin
      nb = top; nxt = 0;
      for (int r = 0; r < BANKS; r++) begin
        for (int i = 0; i < BANKS; i++) begin
          s = int'(sz[(n*BANKS+i)*AW +: AW]);
          rk = 0;
          for (int j = 0; j < BANKS; j++) begin
            t = int'(sz[(n*BANKS+j)*AW +: AW]);
            if (t > s || (t == s && j < i)) rk++;
          end
          if (s != 0 && rk == r) begin
            if (top > 0 && top < FOUR && top + s > iol) begin
              lowtop = top; seen = 1; top = FOUR;
              if (nb == lowtop) begin nb = FOUR; nxt = 0; end
              else nxt = FOUR - nb;
            end
            e.base[(n*BANKS+i)*AW +: AW] = AW'(nxt);
            e.mask[(n*BANKS+i)*AW +: AW] = AW'(s - 1);
            e.en[n*BANKS+i] = 1'b1;
            nxt += s; top += s;
          end
        end
      end
      e.nb[n*AW +: AW] = AW'(nb);
    end
    if (seen) begin e.tl = AW'(lowtop); e.th = AW'(top); end
    else      begin e.tl = AW'(top);    e.th = '0;       end
    return e;
  endfunction

  // Monitor: pops expectation at every done pulse.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected done", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(cs_en == e.en,       {cur_tag, " R2 R9 enables"}, cs_en, e.en);
          chk(cs_base == e.base,   {cur_tag, " R3 bank bases"}, cs_base, e.base);
          chk(cs_mask == e.mask,   {cur_tag, " R3 masks"}, cs_mask, e.mask);
          chk(node_base == e.nb,   {cur_tag, " R4 node bases"}, node_base, e.nb);
          chk(tom_low == e.tl,     {cur_tag, " R8 tom_low"}, tom_low, e.tl);
          chk(tom_high == e.th,    {cur_tag, " R8 tom_high"}, tom_high, e.th);
          chk(busy == 1'b0,        {cur_tag, " R10 busy at done"}, busy, 0);
        end
      end
    end
  end

  // Driver
  task automatic run_case(input logic [CS*AW-1:0] sz, input int iol, input string tag);
    @(negedge clk);
    cur_tag   = tag;
    bank_size = sz;
    io_low    = AW'(iol);
    start     = 1'b1;
    exp_q.push_back(model(sz, iol));
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R10 busy after start"}, busy, 1);
    wait (exp_q.size() == 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R10 done lasts one cycle"}, done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [CS*AW-1:0] v;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset busy/done", {busy, done}, 0);
    chk(cs_en == '0 && cs_base == '0 && cs_mask == '0, "R1 reset bank outputs", cs_en, 0);
    chk(tom_low == '0 && tom_high == '0 && node_base == '0, "R1 reset tops", {tom_low, tom_high}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2: ties go to the lowest index; exact fit against the window is no hole (R5)
    v = '0;
    v = put(v, 0, 0, 32); v = put(v, 0, 1, 64); v = put(v, 0, 2, 64); v = put(v, 0, 4, 16);
    v = put(v, 1, 7, 8);  v = put(v, 1, 3, 8);
    run_case(v, 192, "R2 R5 ties");

    // R5: zero top never triggers, top at or above 4 GB never triggers
    v = '0; v = put(v, 0, 0, 512); v = put(v, 1, 0, 64);
    run_case(v, 192, "R5 zero top");

    // R6: whole-node move
    v = '0; v = put(v, 0, 0, 128); v = put(v, 0, 5, 64); v = put(v, 1, 2, 64);
    run_case(v, 192, "R6 node move");

    // R7: per-bank move in a later node
    v = '0; v = put(v, 0, 3, 64); v = put(v, 1, 0, 128); v = put(v, 1, 1, 128);
    run_case(v, 192, "R7 bank move node1");

    // R7: per-bank move inside node 0
    v = '0; v = put(v, 0, 0, 128); v = put(v, 0, 6, 64);
    run_case(v, 160, "R7 bank move node0");

    // R4 + R11: empty node keeps running top; previous results cleared
    v = '0; v = put(v, 1, 6, 32);
    run_case(v, 192, "R4 R11 empty node");

    // R1: start while busy is ignored
    v = '0; v = put(v, 0, 0, 128); v = put(v, 0, 5, 64); v = put(v, 1, 2, 64);
    @(negedge clk);
    cur_tag = "R1 start while busy";
    bank_size = v; io_low = AW'(192); start = 1'b1;
    exp_q.push_back(model(v, 192));
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    bank_size = put('0, 0, 1, 16); io_low = AW'(8); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (exp_q.size() == 0);
    repeat (200) @(negedge clk);  // a second done here would be flagged by the monitor
    chk(busy == 1'b0, "R1 no second run", busy, 0);

    // R11: all-zero run leaves nothing enabled
    run_case('0, 192, "R11 all empty");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule